// File: doc/BRIEF.md
# Operator Console Run Controller

This block sits between the front-panel switches of a processor console and the CPU core. It decides whether the CPU may fetch and execute instructions. It does this from start and stop keys, a two-position rate switch (continuous or one instruction at a time), and an optional stop on a matching instruction address. The processor is stopped after reset. A start key sets it running in the mode chosen by the rate switch. The stop key, the end of a single step, or an address match return it to the stopped state. Stopping affects only instruction fetch. Channel activity and pending interruptions live outside this block and are never touched.

While the CPU is stopped, the operator can work on its resources by hand. The store key writes the data switches to a location in main storage, a general register or a floating-point register. The resource comes from the select switch and the location from the address switches. The display key reads the same kinds of location and latches the value on a display output. A set-address key loads the instruction address from the address switches. The manual indicator shows the stopped state. The wait indicator mirrors the wait bit of the status word, and the CPU is held off while it waits with no interruption pending.

Top module: `console_run_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until a key is accepted, the CPU is stopped: `run_en` is 0, `manual_lt` is 1, `acc_valid` and `ia_load` are 0, and `disp_val` is 0.
- R2: A start key in the stopped state with `rate_step`=0 makes `run_en` 1 from the next cycle on, and it stays 1 until a stop condition occurs. A start key that arrives while the CPU is running or stepping is ignored.
- R3: A start key in the stopped state with `rate_step`=1 enables exactly one instruction. `run_en` is 1 from the next cycle until the cycle with `cpu_done`=1, and the CPU is stopped in the cycle after that.
- R4: A stop key stops the CPU from the next cycle, whether it was running or stepping. If stop and start arrive in the same cycle, stop wins.
- R5: `manual_lt` is 1 exactly when the CPU is stopped. `wait_lt` always equals `psw_wait`.
- R6: While `psw_wait`=1 and `irq_pending`=0, `run_en` is 0. As soon as `irq_pending` is 1, the run state decides `run_en` again.
- R7: With `cmp_en`=1 in continuous mode, if `cpu_ia` equals `addr_sw`, `run_en` is 0 in that cycle and the CPU is stopped from the next cycle. The compare is not applied before the first `cpu_done` after a start, and it is not applied in step mode.
- R8: A store key accepted in the stopped state gives, in the next cycle, `acc_valid`=1 and `acc_we`=1, with `acc_tgt`=`sel_sw`, `acc_addr`=`addr_sw` and `acc_wdata`=`data_sw`. The select encoding is 0 for main storage, 1 for general registers and 2 for floating-point registers. A select of 3 produces no access.
- R9: A display key accepted in the stopped state gives, in the next cycle, `acc_valid`=1 and `acc_we`=0 with target and address taken from the switches. One cycle later, `disp_val` holds the read data of the targeted resource, and it is unchanged at all other times.
- R10: A set-address key accepted in the stopped state pulses `ia_load` in the next cycle, with `ia_val`=`addr_sw`.
- R11: Store, display and set-address keys are ignored unless the CPU is stopped. If several arrive together, only one is acted on, with store taking priority over display and display over set-address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_start | input | 1 | Start key pulse |
| key_stop | input | 1 | Stop key pulse |
| key_store | input | 1 | Store key pulse |
| key_display | input | 1 | Display key pulse |
| key_set_ia | input | 1 | Set-instruction-address key pulse |
| rate_step | input | 1 | Rate switch: 0 continuous, 1 single instruction |
| sel_sw | input | 2 | Resource select: 0 main, 1 general reg, 2 float reg |
| addr_sw | input | AW | Address switches |
| data_sw | input | DW | Data switches |
| cmp_en | input | 1 | Enable instruction-address compare stop |
| cpu_ia | input | AW | Address of the next instruction from the CPU |
| cpu_done | input | 1 | CPU finished an instruction |
| psw_wait | input | 1 | Wait bit of the status word |
| irq_pending | input | 1 | An interruption condition is pending |
| mem_rdata | input | DW | Main storage read data for `acc_addr` |
| gpr_rdata | input | DW | General register read data for `acc_addr` |
| fpr_rdata | input | DW | Floating register read data for `acc_addr` |
| run_en | output | 1 | CPU may fetch and execute |
| acc_valid | output | 1 | Manual access request |
| acc_we | output | 1 | Manual access is a write |
| acc_tgt | output | 2 | Target resource of the access |
| acc_addr | output | AW | Address or register number of the access |
| acc_wdata | output | DW | Write data of the access |
| ia_load | output | 1 | Load the instruction address |
| ia_val | output | AW | Instruction address to load |
| disp_val | output | DW | Displayed value |
| manual_lt | output | 1 | Manual (stopped) indicator |
| wait_lt | output | 1 | Wait indicator |

## Verification
The hardest case to reach is a compare hit that lands exactly on the first instruction after a start. It needs a stopped CPU, continuous mode, compare enabled and `cpu_ia` equal to the switches, all at the moment the start key is taken. The directed part sets up that case and the case where the match arrives only after the first `cpu_done`. The random part draws `cpu_ia` and `addr_sw` from an eight-value range so that matches also occur together with waits, stops and steps.

// File: rtl/con_pkg.sv
package con_pkg;
  typedef enum logic [1:0] {
    RS_STOP = 2'd0,
    RS_RUN  = 2'd1,
    RS_STEP = 2'd2
  } run_state_e;

  typedef enum logic [1:0] {
    SEL_MAIN = 2'd0,
    SEL_GPR  = 2'd1,
    SEL_FPR  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;
endpackage

// File: rtl/con_run_fsm.sv
module con_run_fsm
  import con_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_start,
  input  logic          key_stop,
  input  logic          rate_step,
  input  logic          cmp_en,
  input  logic [AW-1:0] cmp_addr,
  input  logic [AW-1:0] cpu_ia,
  input  logic          cpu_done,
  input  logic          psw_wait,
  input  logic          irq_pending,
  output logic          run_en,
  output logic          stopped
);
  run_state_e state_q, state_d;
  logic       first_q, first_d;
  logic       state_upd, first_upd;
  logic       start_ok, cmp_hit, wait_blk;

  assign stopped  = (state_q == RS_STOP);
  assign start_ok = stopped & key_start & ~key_stop;
  assign cmp_hit  = (state_q == RS_RUN) & cmp_en & (cpu_ia == cmp_addr) & ~first_q;
  assign wait_blk = psw_wait & ~irq_pending;
  assign run_en   = (((state_q == RS_RUN) & ~cmp_hit) | (state_q == RS_STEP)) & ~wait_blk;

  always_comb begin
    state_d = state_q;
    if (key_stop) begin
      state_d = RS_STOP;
    end else begin
      unique case (state_q)
        RS_STOP: if (key_start) state_d = rate_step ? RS_STEP : RS_RUN;
        RS_RUN:  if (cmp_hit)   state_d = RS_STOP;
        RS_STEP: if (cpu_done)  state_d = RS_STOP;
        default: state_d = RS_STOP;
      endcase
    end
    state_upd = (state_d != state_q);
  end

  always_comb begin
    first_d = first_q;
    if (start_ok)      first_d = 1'b1;
    else if (cpu_done) first_d = 1'b0;
    first_upd = (first_d != first_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_STOP;
      first_q <= 1'b0;
    end else begin
      if (state_upd) state_q <= state_d;
      if (first_upd) first_q <= first_d;
    end
  end

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    key_stop |=> stopped); // R4
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && key_start && !key_stop && !rate_step) |=> (state_q == RS_RUN)); // R2
  AST_STEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == RS_STEP) && cpu_done) |=> stopped); // R3
  AST_CMP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == RS_RUN) && cmp_en && (cpu_ia == cmp_addr) && !first_q) |=> stopped); // R7
  AST_STOPPED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !run_en); // R5
endmodule

// File: rtl/con_manual.sv
module con_manual
  import con_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stopped,
  input  logic          key_store,
  input  logic          key_display,
  input  logic          key_set_ia,
  input  logic [1:0]    sel_sw,
  input  logic [AW-1:0] addr_sw,
  input  logic [DW-1:0] data_sw,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] gpr_rdata,
  input  logic [DW-1:0] fpr_rdata,
  output logic          acc_valid,
  output logic          acc_we,
  output logic [1:0]    acc_tgt,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          ia_load,
  output logic [AW-1:0] ia_val,
  output logic [DW-1:0] disp_val
);
  logic          do_store, do_disp, do_ia, sel_ok, req_upd, disp_upd;
  logic          valid_d, ia_load_d;
  logic [DW-1:0] rd_mux;

  assign sel_ok    = (sel_sw != SEL_NONE);
  assign do_store  = stopped & key_store;
  assign do_disp   = stopped & key_display & ~key_store;
  assign do_ia     = stopped & key_set_ia & ~key_store & ~key_display;
  assign valid_d   = (do_store | do_disp) & sel_ok;
  assign ia_load_d = do_ia;
  assign req_upd   = valid_d;
  assign disp_upd  = acc_valid & ~acc_we;

  always_comb begin
    unique case (acc_tgt)
      SEL_MAIN: rd_mux = mem_rdata;
      SEL_GPR:  rd_mux = gpr_rdata;
      SEL_FPR:  rd_mux = fpr_rdata;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_we    <= 1'b0;
      acc_tgt   <= '0;
      acc_addr  <= '0;
      acc_wdata <= '0;
      ia_load   <= 1'b0;
      ia_val    <= '0;
      disp_val  <= '0;
    end else begin
      acc_valid <= valid_d;
      ia_load   <= ia_load_d;
      if (req_upd) begin
        acc_we    <= do_store;
        acc_tgt   <= sel_sw;
        acc_addr  <= addr_sw;
        acc_wdata <= data_sw;
      end
      if (do_ia)    ia_val   <= addr_sw;
      if (disp_upd) disp_val <= rd_mux;
    end
  end

  AST_ACCESS_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid || ia_load) |-> $past(stopped)); // R11
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && ia_load)); // R11
  AST_NO_BAD_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_tgt != SEL_NONE)); // R8
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(acc_valid && !acc_we) |-> $stable(disp_val)); // R9
endmodule

// File: rtl/console_run_ctrl.sv
module console_run_ctrl
  import con_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_start,
  input  logic          key_stop,
  input  logic          key_store,
  input  logic          key_display,
  input  logic          key_set_ia,
  input  logic          rate_step,
  input  logic [1:0]    sel_sw,
  input  logic [AW-1:0] addr_sw,
  input  logic [DW-1:0] data_sw,
  input  logic          cmp_en,
  input  logic [AW-1:0] cpu_ia,
  input  logic          cpu_done,
  input  logic          psw_wait,
  input  logic          irq_pending,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] gpr_rdata,
  input  logic [DW-1:0] fpr_rdata,
  output logic          run_en,
  output logic          acc_valid,
  output logic          acc_we,
  output logic [1:0]    acc_tgt,
  output logic [AW-1:0] acc_addr,
  output logic [DW-1:0] acc_wdata,
  output logic          ia_load,
  output logic [AW-1:0] ia_val,
  output logic [DW-1:0] disp_val,
  output logic          manual_lt,
  output logic          wait_lt
);
  logic stopped;

  con_run_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_start  (key_start),
    .key_stop   (key_stop),
    .rate_step  (rate_step),
    .cmp_en     (cmp_en),
    .cmp_addr   (addr_sw),
    .cpu_ia     (cpu_ia),
    .cpu_done   (cpu_done),
    .psw_wait   (psw_wait),
    .irq_pending(irq_pending),
    .run_en     (run_en),
    .stopped    (stopped)
  );

  con_manual #(.AW(AW), .DW(DW)) u_man (
    .clk        (clk),
    .rst_n      (rst_n),
    .stopped    (stopped),
    .key_store  (key_store),
    .key_display(key_display),
    .key_set_ia (key_set_ia),
    .sel_sw     (sel_sw),
    .addr_sw    (addr_sw),
    .data_sw    (data_sw),
    .mem_rdata  (mem_rdata),
    .gpr_rdata  (gpr_rdata),
    .fpr_rdata  (fpr_rdata),
    .acc_valid  (acc_valid),
    .acc_we     (acc_we),
    .acc_tgt    (acc_tgt),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .ia_load    (ia_load),
    .ia_val     (ia_val),
    .disp_val   (disp_val)
  );

  assign manual_lt = stopped;
  assign wait_lt   = psw_wait;

  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (psw_wait && !irq_pending) |-> !run_en); // R6
endmodule

// File: tb/sim_console_run_ctrl.sv
module sim_console_run_ctrl;
  localparam int AW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_start = 0, key_stop = 0, key_store = 0, key_display = 0, key_set_ia = 0;
  logic rate_step = 0, cmp_en = 0, cpu_done = 0, psw_wait = 0, irq_pending = 0;
  logic [1:0]    sel_sw = 0;
  logic [AW-1:0] addr_sw = 0, cpu_ia = 0;
  logic [DW-1:0] data_sw = 0;
  logic [DW-1:0] mem_rdata, gpr_rdata, fpr_rdata;
  logic          run_en, acc_valid, acc_we, ia_load, manual_lt, wait_lt;
  logic [1:0]    acc_tgt;
  logic [AW-1:0] acc_addr, ia_val;
  logic [DW-1:0] acc_wdata, disp_val;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] rd_model(logic [1:0] t, logic [AW-1:0] a);
    case (t)
      2'd0: return {8'hA0, a};
      2'd1: return {8'hB1, a};
      2'd2: return {8'hC2, a};
      default: return '0;
    endcase
  endfunction

  assign mem_rdata = rd_model(2'd0, acc_addr);
  assign gpr_rdata = rd_model(2'd1, acc_addr);
  assign fpr_rdata = rd_model(2'd2, acc_addr);

  console_run_ctrl #(.AW(AW), .DW(DW)) u0 (.*);

  // reference state: 0 stopped, 1 running, 2 stepping
  int            m_st = 0;
  bit            m_first = 0, m_pstop = 0;
  bit            m_av = 0, m_we = 0, m_il = 0;
  logic [1:0]    m_tgt = 0;
  logic [AW-1:0] m_addr = 0, m_iav = 0;
  logic [DW-1:0] m_wdata = 0, m_disp = 0;

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cyc();
    bit hit, wblk, exp_run, n_av, n_we, n_il, n_first, n_pstop;
    int n_st;
    string t;
    logic [1:0] n_tgt;
    logic [AW-1:0] n_addr, n_iav;
    logic [DW-1:0] n_wdata, n_disp;
    #1;
    hit  = cmp_en && (cpu_ia == addr_sw) && !m_first && m_st == 1;
    wblk = psw_wait && !irq_pending;
    exp_run = ((m_st == 1 && !hit) || m_st == 2) && !wblk;
    t = m_pstop ? "R4" : hit ? "R7" : wblk ? "R6" : (m_st == 2) ? "R3" : "R2";
    chk(run_en == exp_run, t, DW'(run_en), DW'(exp_run), "run_en");
    chk(manual_lt == (m_st == 0), "R5", DW'(manual_lt), DW'(m_st == 0), "manual_lt");
    chk(wait_lt == psw_wait, "R5", DW'(wait_lt), DW'(psw_wait), "wait_lt");
    chk(acc_valid == m_av, "R11", DW'(acc_valid), DW'(m_av), "acc_valid");
    if (m_av) begin
      chk(acc_we == m_we, m_we ? "R8" : "R9", DW'(acc_we), DW'(m_we), "acc_we");
      chk(acc_tgt == m_tgt, "R8", DW'(acc_tgt), DW'(m_tgt), "acc_tgt");
      chk(acc_addr == m_addr, "R8", DW'(acc_addr), DW'(m_addr), "acc_addr");
      if (m_we) chk(acc_wdata == m_wdata, "R8", acc_wdata, m_wdata, "acc_wdata");
    end
    chk(ia_load == m_il, "R10", DW'(ia_load), DW'(m_il), "ia_load");
    if (m_il) chk(ia_val == m_iav, "R10", DW'(ia_val), DW'(m_iav), "ia_val");
    chk(disp_val == m_disp, "R9", disp_val, m_disp, "disp_val");

    n_st = m_st; n_first = m_first; n_pstop = key_stop;
    if (key_stop) n_st = 0;
    else if (m_st == 0 && key_start) begin n_st = rate_step ? 2 : 1; end
    else if (m_st == 1 && hit) n_st = 0;
    else if (m_st == 2 && cpu_done) n_st = 0;
    if (m_st == 0 && key_start && !key_stop) n_first = 1;
    else if (cpu_done) n_first = 0;

    n_av = 0; n_il = 0; n_we = m_we; n_tgt = m_tgt; n_addr = m_addr;
    n_wdata = m_wdata; n_iav = m_iav; n_disp = m_disp;
    if (m_st == 0) begin
      if (key_store || key_display) begin
        n_av = (sel_sw != 2'd3);
        if (n_av) begin
          n_we = key_store; n_tgt = sel_sw; n_addr = addr_sw; n_wdata = data_sw;
        end
      end else if (key_set_ia) begin
        n_il = 1; n_iav = addr_sw;
      end
    end
    if (m_av && !m_we) n_disp = rd_model(m_tgt, m_addr);

    @(posedge clk);
    m_st = n_st; m_first = n_first; m_pstop = n_pstop;
    m_av = n_av; m_we = n_we; m_il = n_il; m_tgt = n_tgt; m_addr = n_addr;
    m_wdata = n_wdata; m_iav = n_iav; m_disp = n_disp;
    @(negedge clk);
    {key_start, key_stop, key_store, key_display, key_set_ia, cpu_done} = '0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(run_en == 0 && manual_lt == 1, "R1", DW'({run_en, manual_lt}), 32'h1, "run/manual in reset");
    chk(acc_valid == 0 && ia_load == 0 && disp_val == 0, "R1", disp_val, 0, "access/display in reset");
    rst_n = 1'b1;
    cyc(); cyc();

    // R2: continuous start, start while running ignored
    key_start = 1; cyc();
    repeat (3) begin cpu_done = 1; cyc(); end
    key_start = 1; rate_step = 1; cyc();
    // R11: manual keys while running ignored
    key_store = 1; sel_sw = 0; addr_sw = 5; cyc();
    key_display = 1; cyc();
    key_set_ia = 1; cyc();
    // R6: wait without then with pending interruption
    psw_wait = 1; cyc(); cyc();
    irq_pending = 1; cyc();
    psw_wait = 0; irq_pending = 0; cyc();
    // R4: stop, then stop with start together
    key_stop = 1; cyc(); cyc();
    key_stop = 1; key_start = 1; cyc(); cyc();

    // R3: single step
    rate_step = 1; key_start = 1; cyc(); cyc(); cpu_done = 1; cyc(); cyc();
    // R3/R4: stop during step
    key_start = 1; cyc(); key_stop = 1; cyc(); cyc();

    // R7: match on first instruction after start is skipped, next match stops
    rate_step = 0; cmp_en = 1; addr_sw = 24'h40; cpu_ia = 24'h40;
    key_start = 1; cyc(); cyc();
    cpu_done = 1; cpu_ia = 24'h44; cyc();
    cpu_done = 1; cpu_ia = 24'h40; cyc(); cyc();
    // R7: no compare in step mode
    rate_step = 1; key_start = 1; cyc(); cyc(); cpu_done = 1; cyc(); cyc();
    cmp_en = 0;

    // R8: stores to each resource, select 3 gives nothing
    for (int s = 0; s < 4; s++) begin
      key_store = 1; sel_sw = 2'(s); addr_sw = AW'(16 + s); data_sw = 32'hDEAD0000 + s; cyc(); cyc();
    end
    // R9: displays of each resource
    for (int s = 0; s < 4; s++) begin
      key_display = 1; sel_sw = 2'(s); addr_sw = AW'(32 + s); cyc(); cyc(); cyc();
    end
    // R10 and R11 priority
    key_set_ia = 1; addr_sw = 24'h123456; cyc(); cyc();
    key_set_ia = 1; key_display = 1; sel_sw = 1; cyc(); cyc(); cyc();
    key_set_ia = 1; key_display = 1; key_store = 1; sel_sw = 2; cyc(); cyc(); cyc();

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      key_start   = ($urandom % 8) == 0;
      key_stop    = ($urandom % 14) == 0;
      key_store   = ($urandom % 9) == 0;
      key_display = ($urandom % 9) == 0;
      key_set_ia  = ($urandom % 12) == 0;
      if (($urandom % 16) == 0) rate_step = $urandom % 2;
      sel_sw  = 2'($urandom % 4);
      addr_sw = AW'($urandom % 8);
      data_sw = $urandom;
      cmp_en  = ($urandom % 2) == 0;
      cpu_ia  = AW'($urandom % 8);
      cpu_done = (m_st != 0) && (($urandom % 3) == 0);
      psw_wait = ($urandom % 5) == 0;
      irq_pending = ($urandom % 2) == 0;
      cyc();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule